// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Deserializer

This block turns a one-bit serial stream into parallel words of `N` bits. A new serial bit is sampled on each clock edge where the bit-enable input is high. An edge where the enable is low samples nothing and does not move the bit position. The bits go into a shift register. When the `N`th bit of a word arrives, the whole word is copied into a separate holding register, and that register drives the parallel output. The output therefore stays fixed for a whole word period while the next word is shifted in behind it.

A bit counter divides the serial bit rate by `N`. From this division the block makes two word-rate signals: a one-cycle strobe each time a new word is held, and a phase signal that changes level once per word. A two-state controller records whether any complete word has been held since reset. It starts in `ST_PRIME`, where no word has been held. On the first word completion it takes the transition `PRIME_TO_LIVE` to `ST_LIVE`. It then stays in `ST_LIVE` through the transition `LIVE_HOLD` until the next reset.

Bit alignment comes from reset alone: the first enabled bit after reset begins a word. The block does not recover a clock and does not search for a word boundary in the line code.

Top module: `ser2par_deser`

## Requirements
- R1: While `rst_n` is low, and until the first word completes, `par_word`, `word_stb`, `word_phase` and `held_valid` are all 0.
- R2: Serial bits are placed most-significant first. The first enabled bit of a word appears in `par_word[N-1]` and the last enabled bit appears in `par_word[0]`.
- R3: `word_stb` is high for exactly one clock cycle, the cycle that follows the edge on which the `N`th enabled bit of a word is sampled. `par_word` shows the new word in that same cycle. Otherwise `word_stb` is 0.
- R4: `par_word` changes only on a word-completion edge. Bits that arrive while a word is partly received leave it unchanged.
- R5: `word_phase` inverts on every word-completion edge and holds its level at every other edge. Its period is therefore 2·N enabled bits.
- R6: `held_valid` is 0 in `ST_PRIME` and 1 in `ST_LIVE`. It rises together with the first `word_stb` after reset, and it stays high until the next reset.
- R7: An edge with `bit_en` low samples no bit, whatever value `bit_in` has. It changes neither the bit position nor any output.
- R8: A reset applied while a word is partly received discards the partial bits. The first enabled bit after the reset becomes the most-significant bit of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-side clock |
| rst_n | input | 1 | Active-low synchronous reset; sets bit alignment |
| bit_en | input | 1 | Serial bit enable; samples `bit_in` when high |
| bit_in | input | 1 | Serial data bit |
| par_word | output | N | Held parallel word |
| word_stb | output | 1 | One-cycle pulse when a new word is held |
| word_phase | output | 1 | Word-rate phase; inverts once per word |
| held_valid | output | 1 | High once any complete word has been held |

## Verification
The assertions check on every cycle that the bit count stays in range and is frozen while the enable is low. They also check that the held word changes only on a load, that each strobe follows a load and lasts a single cycle, and that the phase inverts with every strobe. Finally, they check that `held_valid` never falls and rises only on a load. The bit ordering (R2), the exact value of each held word, and the realignment after a mid-word reset (R8) can only be shown by the bench. The bench feeds every 4-bit word, then random words with idle gaps and noise on `bit_in`, then back-to-back words. It compares each held word and each strobe cycle against a model of the serial order kept in the bench.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_LIVE  = 1'b1
    } deser_state_e;

endpackage

// File: rtl/rx_bit_counter.sv
module rx_bit_counter #(
    parameter int N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic load_o
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;

    assign load_o = bit_en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bit_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                             // R3
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(cnt_q));                                // R7

endmodule

// File: rtl/rx_shift_reg.sv
module rx_shift_reg #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         bit_in,
    output logic [N-1:0] word_nx_o
);
    // Only N-1 bits are stored; the last bit goes straight to the hold register.
    localparam int SW = N - 1;

    logic [SW-1:0] sh_q;

    assign word_nx_o = {sh_q, bit_in};

    generate
        if (SW == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n)      sh_q <= '0;
                else if (bit_en) sh_q <= bit_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n)      sh_q <= '0;
                else if (bit_en) sh_q <= {sh_q[SW-2:0], bit_in};
            end
        end
    endgenerate

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(sh_q));                                 // R7

endmodule

// File: rtl/rx_word_hold.sv
module rx_word_hold #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] word_nx_i,
    output logic [N-1:0] hold_o,
    output logic         stb_o,
    output logic         phase_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o  <= '0;
            stb_o   <= 1'b0;
            phase_o <= 1'b0;
        end else begin
            stb_o <= load_i;
            if (load_i) begin
                hold_o  <= word_nx_i;
                phase_o <= ~phase_o;
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(hold_o));                               // R4
    AST_STB_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(load_i));                                   // R3
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);                                          // R3
    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> (phase_o != $past(phase_o)));                     // R5

endmodule

// File: rtl/rx_deser_fsm.sv
module rx_deser_fsm
    import ser2par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic valid_o
);
    deser_state_e st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_PRIME: if (load_i) st_nx = ST_LIVE;   // PRIME_TO_LIVE
            ST_LIVE:  st_nx = ST_LIVE;               // LIVE_HOLD
            default:  st_nx = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_PRIME;
        else        st_q <= st_nx;
    end

    always_comb begin
        valid_o = (st_q == ST_LIVE);
    end

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);                                       // R6
    AST_VALID_RISE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(load_i));                          // R6

endmodule

// File: rtl/ser2par_deser.sv
module ser2par_deser #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         bit_in,
    output logic [N-1:0] par_word,
    output logic         word_stb,
    output logic         word_phase,
    output logic         held_valid
);
    logic         load;
    logic [N-1:0] word_nx;

    initial begin
        if (N < 2) $error("ser2par_deser: N must be at least 2");
    end

    rx_bit_counter #(.N(N)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .load_o (load)
    );

    rx_shift_reg #(.N(N)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .word_nx_o (word_nx)
    );

    rx_word_hold #(.N(N)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .word_nx_i (word_nx),
        .hold_o    (par_word),
        .stb_o     (word_stb),
        .phase_o   (word_phase)
    );

    rx_deser_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .valid_o (held_valid)
    );

    AST_VALID_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !$past(held_valid)) |-> held_valid);           // R6

endmodule

// File: tb/ser2par_deser_tb.sv
module ser2par_deser_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_en = 1'b0;
    logic         bit_in = 1'b0;
    logic [N-1:0] par_word;
    logic         word_stb, word_phase, held_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cyc = 0;

    logic [N-1:0] acc, exp_word;
    int           pos;
    logic         exp_phase, exp_valid;

    always #10 clk = ~clk;   // 50 MHz

    ser2par_deser #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .par_word(par_word), .word_stb(word_stb),
        .word_phase(word_phase), .held_valid(held_valid)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        acc = '0; exp_word = '0; pos = 0; exp_phase = 1'b0; exp_valid = 1'b0;
    endtask

    task automatic check_quiet(input string tag);
        chk(word_stb == 1'b0, {tag, " R3 strobe low"}, 32'(word_stb), 0);
        chk(par_word == exp_word, {tag, " R4 word held"}, 32'(par_word), 32'(exp_word));
        chk(word_phase == exp_phase, {tag, " R5 phase held"}, 32'(word_phase), 32'(exp_phase));
        chk(held_valid == exp_valid, {tag, " R6 valid"}, 32'(held_valid), 32'(exp_valid));
    endtask

    task automatic push(input logic b, input int gap);
        @(negedge clk);
        bit_en = 1'b1; bit_in = b;
        @(posedge clk); #2;
        acc = {acc[N-2:0], b};
        if (pos == N - 1) begin
            pos = 0;
            exp_word = acc;
            exp_phase = ~exp_phase;
            exp_valid = 1'b1;
            chk(word_stb == 1'b1, "R3 strobe on last bit", 32'(word_stb), 1);
            chk(par_word == exp_word, "R2 word order MSB first", 32'(par_word), 32'(exp_word));
            chk(word_phase == exp_phase, "R5 phase flips", 32'(word_phase), 32'(exp_phase));
            chk(held_valid == 1'b1, "R6 valid after word", 32'(held_valid), 1);
        end else begin
            pos++;
            check_quiet("mid-word");
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_en = 1'b0; bit_in = 1'($urandom);
            @(posedge clk); #2;
            check_quiet("R7 idle edge");
        end
    endtask

    task automatic send_word(input logic [N-1:0] w, input int gap);
        for (int i = N - 1; i >= 0; i--) push(w[i], gap);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk(par_word == '0, "R1 reset word", 32'(par_word), 0);
        chk(word_stb == 1'b0, "R1 reset strobe", 32'(word_stb), 0);
        chk(word_phase == 1'b0, "R1 reset phase", 32'(word_phase), 0);
        chk(held_valid == 1'b0, "R1 reset valid", 32'(held_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1: nothing valid before the first word completes
        push(1'b1, 1); push(1'b0, 0); push(1'b1, 2);
        chk(held_valid == 1'b0, "R1 no valid before first word", 32'(held_valid), 0);
        push(1'b1, 0);
        // exhaustive sweep of every N-bit word, with differing gap patterns
        for (int w = 0; w < (1 << N); w++) send_word(N'(w), w % 3);
        // random words with noisy idle gaps
        for (int k = 0; k < 40; k++) send_word(N'($urandom), int'($urandom_range(0, 2)));
        // back-to-back words at full rate
        for (int k = 0; k < 8; k++) send_word(N'($urandom), 0);
        // R8: reset part way through a word realigns
        push(1'b1, 0); push(1'b1, 0);
        do_reset();
        send_word(4'b0110, 0);
        chk(par_word == 4'b0110, "R8 realigned word", 32'(par_word), 32'h6);
        send_word(4'b1001, 1);
        chk(par_word == 4'b1001, "R8 second word after reset", 32'(par_word), 32'h9);
        @(negedge clk);
        bit_en = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule